// File: doc/BRIEF.md
# Word-Serial Rotator with On-Line Scale Compensation

The block turns a complex sample (x, y) through an angle that an external angle recoder has already broken into a short list of double micro-rotations. Every recoder beat carries a direction and two shift indices (s, t). The block spends one clock cycle per beat. In that cycle it applies the shift-and-add rotation by index s and then the one by index t.

Each micro-rotation with index m stretches the vector by 1/cos(atan 2^-m). The block does not collect this gain for a correction at the end. It shrinks the vector on line instead, by (1 - 2^-(2m+1)), and folds at most one such step into each cycle. Indices that cannot be served at once wait in a small queue. For indices 1 and 2 this first-order factor is too coarse, so a few fixed (1 + 2^-c) trims are also recorded. They run once the rotations and the queued shrinks are complete. The total cycle count is therefore close to the larger of the rotation count and the compensation count, rather than the sum of the two.

The internal words keep three fraction bits and two headroom bits beyond the 12-bit sample. The result is rounded and saturated back to 12 bits and held on the outputs. A one-cycle done pulse marks it. A start with the zero-angle flag set returns the input unchanged.

Top module: `online_scale_cordic`

## Requirements
- R1: After reset, done, busy and step_ready are low and x_out and y_out are zero.
- R2: An accepted beat with dir=1 turns the vector counterclockwise (x gets x - y·2^-s, then the same step with t). With dir=0 it turns clockwise. For input magnitudes up to 1000 and indices s, t ≥ 1, the result is within 2 LSB of an ideal unit-gain rotation by the sum of d·(atan 2^-s + atan 2^-t).
- R3: Every index m with 1 ≤ m ≤ IO_W/2-1 receives exactly one shrink (1 - 2^-(2m+1)), and at most one shrink is applied per cycle. Queued indices are served first, then the current s, then the current t. Larger indices receive none.
- R4: Index 1 adds the trims (1+2^-6) and (1+2^-7). Index 2 adds (1+2^-10) and (1+2^-11). The trims run one per cycle, and only after the last beat and after the shrink queue is empty.
- R5: The number of clock edges from the edge that takes start to the edge that raises done is Tr + Q + E. Here Tr is the number of beats, Q is the count of shrinks still queued after the last beat, and E is the number of trims.
- R6: A start with angle_zero=1 puts x_in and y_in unchanged on the outputs and raises done on the same edge.
- R7: done is high for one cycle per completion. x_out and y_out change only on an edge that raises done.
- R8: Outputs are rounded half-up from the internal fraction bits and saturated to the signed IO_W range.
- R9: A start while busy is ignored and does not disturb the run in progress.
- R10: step_ready is high only while beats are being taken. A beat is taken only when step_valid and step_ready are both high. The beat marked step_last ends the rotation phase.
- R11: The shrink queue never holds more than QDEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a rotation of x_in, y_in (taken when idle) |
| angle_zero | input | 1 | With start: angle is zero, pass the input through |
| x_in | input | IO_W | Real part of the input, signed |
| y_in | input | IO_W | Imaginary part of the input, signed |
| step_ready | output | 1 | Block takes a recoder beat this cycle |
| step_valid | input | 1 | Recoder beat present |
| step_dir | input | 1 | 1 = counterclockwise, 0 = clockwise |
| step_s | input | IDX_W | First micro-rotation index (≥ 1) |
| step_t | input | IDX_W | Second micro-rotation index (≥ 1) |
| step_last | input | 1 | Residual angle is zero after this beat |
| busy | output | 1 | A rotation is in progress |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | IO_W | Rotated real part, held |
| y_out | output | IO_W | Rotated imaginary part, held |

## Verification
The assertions check on every cycle that served shrink indices stay in the range that needs them, that no trim runs while a shrink is queued or being served, that the queue cannot overflow, that outputs move only with done, and that a zero-angle start passes the sample through on the next edge. Only the bench scenarios can show that the results track an ideal rotation across many angles within two LSB. The same holds for the cycle counts predicted from the queue backlog and the trim count, for saturation, and for a stray start being ignored mid-run.

// File: rtl/ols_pkg.sv
// Shared types and constants of the on-line scale compensated rotator.
// Assumes a 12-bit result: the trim table below is tuned for that accuracy.
package ols_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ROT   = 2'd1,
        PH_DRAIN = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SC_NONE   = 2'd0,
        SC_SHRINK = 2'd1,
        SC_GROW   = 2'd2
    } scale_op_e;

    // number of second-order trim slots
    localparam int ERR_SLOTS = 4;

    // right-shift of the (1 + 2^-c) trim held in each slot
    function automatic int err_shift(input int slot);
        case (slot)
            0:       return 6;
            1:       return 7;
            2:       return 10;
            default: return 11;
        endcase
    endfunction

    // micro-rotation index that makes a slot necessary
    function automatic int err_source(input int slot);
        return (slot < 2) ? 1 : 2;
    endfunction

endpackage

// File: rtl/ols_rotate_pair.sv
// Two cascaded shift-and-add micro-rotations, first by index sh_a, then by sh_b.
// dir=1 turns counterclockwise. With en low the vector passes unchanged.
// Assumes the caller gives enough headroom for the 1/cos gain of both steps.
module ols_rotate_pair #(
    parameter int DW = 17,
    parameter int IW = 4
) (
    input  logic                 en,
    input  logic                 dir,
    input  logic [IW-1:0]        sh_a,
    input  logic [IW-1:0]        sh_b,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] y_i,
    output logic signed [DW-1:0] x_o,
    output logic signed [DW-1:0] y_o
);

    logic signed [DW-1:0] xs_a, ys_a, x_m, y_m, xs_b, ys_b, x_f, y_f;

    // cascade of the two micro-rotations
    always_comb begin
        xs_a = x_i >>> sh_a;
        ys_a = y_i >>> sh_a;
        x_m  = dir ? (x_i - ys_a) : (x_i + ys_a);
        y_m  = dir ? (y_i + xs_a) : (y_i - xs_a);
        xs_b = x_m >>> sh_b;
        ys_b = y_m >>> sh_b;
        x_f  = dir ? (x_m - ys_b) : (x_m + ys_b);
        y_f  = dir ? (y_m + xs_b) : (y_m - xs_b);
        x_o  = en ? x_f : x_i;
        y_o  = en ? y_f : y_i;
    end

endmodule

// File: rtl/ols_scale_step.sv
// One shift-and-add gain step on a single axis: v*(1-2^-sh), v*(1+2^-sh) or v.
// Assumes sh is below DW.
module ols_scale_step #(
    parameter int DW = 17,
    parameter int SW = 5
) (
    input  ols_pkg::scale_op_e   op,
    input  logic [SW-1:0]        sh,
    input  logic signed [DW-1:0] v_i,
    output logic signed [DW-1:0] v_o
);
    import ols_pkg::*;

    logic signed [DW-1:0] part;

    // select the gain step
    always_comb begin
        part = v_i >>> sh;
        case (op)
            SC_SHRINK: v_o = v_i - part;
            SC_GROW:   v_o = v_i + part;
            default:   v_o = v_i;
        endcase
    end

endmodule

// File: rtl/ols_comp_queue.sv
// Queue of micro-rotation indices still owed a first-order shrink.
// Each cycle it serves one index: the oldest queued, else incoming a, else incoming b.
// Incoming indices that are not served are pushed. Only 1..THRESH are accepted.
// Assumes DEPTH is a power of two and inputs are qualified by in_valid.
module ols_comp_queue #(
    parameter int IW     = 4,
    parameter int DEPTH  = 8,
    parameter int THRESH = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          in_valid,
    input  logic [IW-1:0] in_a,
    input  logic [IW-1:0] in_b,
    output logic          out_valid,
    output logic [IW-1:0] out_idx,
    output logic          q_empty,
    output logic          empty_next
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [IW-1:0] THR = IW'(THRESH);

    logic [IW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count, count_next;
    logic          elig_a, elig_b, pop;
    logic [1:0]    push_n;
    logic [IW-1:0] p0, p1;

    // which incoming indices owe a shrink
    always_comb begin
        elig_a = in_valid && (in_a != '0) && (in_a <= THR);
        elig_b = in_valid && (in_b != '0) && (in_b <= THR);
    end

    // serve one index and decide what gets pushed
    always_comb begin
        pop       = 1'b0;
        out_valid = 1'b0;
        out_idx   = '0;
        push_n    = 2'd0;
        p0        = '0;
        p1        = '0;
        if (active) begin
            if (count != '0) begin
                pop       = 1'b1;
                out_valid = 1'b1;
                out_idx   = mem[rd_ptr];
                if (elig_a && elig_b) begin
                    push_n = 2'd2; p0 = in_a; p1 = in_b;
                end else if (elig_a) begin
                    push_n = 2'd1; p0 = in_a;
                end else if (elig_b) begin
                    push_n = 2'd1; p0 = in_b;
                end
            end else if (elig_a) begin
                out_valid = 1'b1;
                out_idx   = in_a;
                if (elig_b) begin
                    push_n = 2'd1; p0 = in_b;
                end
            end else if (elig_b) begin
                out_valid = 1'b1;
                out_idx   = in_b;
            end
        end
        count_next = count + CW'(push_n) - CW'(pop);
        q_empty    = (count == '0);
        empty_next = (count_next == '0);
    end

    // pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            rd_ptr <= rd_ptr + PW'(pop);
            wr_ptr <= wr_ptr + PW'(push_n);
            count  <= count_next;
        end
    end

    // index storage, no reset needed
    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wr_ptr] <= p0;
        if (push_n == 2'd2) mem[wr_ptr + PW'(1)] <= p1;
    end

    AST_QUEUE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !((int'(count) == DEPTH) && (int'(push_n) > int'(pop)))); // R11

    AST_COMP_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_idx != '0) && (out_idx <= THR))); // R3

endmodule

// File: rtl/ols_err_bank.sv
// Counters of owed second-order trims, one per table slot.
// A beat adds to the slots whose source index matches s or t. While draining,
// the lowest non-empty slot is served, one per cycle.
// Assumes incrementing and draining never happen in the same cycle.
module ols_err_bank #(
    parameter int IW    = 4,
    parameter int SW    = 5,
    parameter int CNT_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc_valid,
    input  logic [IW-1:0] idx_a,
    input  logic [IW-1:0] idx_b,
    input  logic          drain_en,
    output logic          out_valid,
    output logic [SW-1:0] out_shift,
    output logic          zero_next
);
    import ols_pkg::*;

    localparam int SLW = $clog2(ERR_SLOTS);

    logic [CNT_W-1:0] cnt      [ERR_SLOTS];
    logic [CNT_W-1:0] cnt_next [ERR_SLOTS];
    logic [SW-1:0]    shift_tab[ERR_SLOTS];
    logic [ERR_SLOTS-1:0] nz, nz_next;
    logic [SLW-1:0]   pick;
    logic             pick_valid;

    for (genvar g = 0; g < ERR_SLOTS; g++) begin : g_slot
        localparam logic [IW-1:0] SRC = IW'(err_source(g));
        logic [1:0] inc;
        logic       dec;

        assign shift_tab[g] = SW'(err_shift(g));
        assign nz[g]        = (cnt[g] != '0);

        // per-slot next count
        always_comb begin
            inc = {1'b0, (inc_valid && (idx_a == SRC))}
                + {1'b0, (inc_valid && (idx_b == SRC))};
            dec = out_valid && (pick == SLW'(g));
            cnt_next[g] = cnt[g] + CNT_W'(inc) - CNT_W'(dec);
            nz_next[g]  = (cnt_next[g] != '0);
        end

        // per-slot counter register
        always_ff @(posedge clk) begin
            if (!rst_n) cnt[g] <= '0;
            else        cnt[g] <= cnt_next[g];
        end
    end

    // lowest non-empty slot wins
    always_comb begin
        pick_valid = 1'b0;
        pick       = '0;
        for (int i = ERR_SLOTS - 1; i >= 0; i--) begin
            if (nz[i]) begin
                pick_valid = 1'b1;
                pick       = SLW'(i);
            end
        end
        out_valid = drain_en && pick_valid;
        out_shift = shift_tab[pick];
        zero_next = (nz_next == '0);
    end

endmodule

// File: rtl/online_scale_cordic.sv
// Word-serial vector rotator. Each recoder beat gives two micro-rotations, and
// one shrink from the compensation queue is folded into the same cycle.
// Once the last beat is in, leftover shrinks and then second-order trims drain
// one per cycle, and the rounded, saturated result is latched with a done pulse.
// Assumes step_s, step_t >= 1 and IO_W = 12 for the trim table.
module online_scale_cordic #(
    parameter int IO_W    = 12,
    parameter int GUARD_W = 3,
    parameter int HEAD_W  = 2,
    parameter int IDX_W   = 4,
    parameter int QDEPTH  = 8,
    parameter int CNT_W   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   angle_zero,
    input  logic signed [IO_W-1:0] x_in,
    input  logic signed [IO_W-1:0] y_in,
    output logic                   step_ready,
    input  logic                   step_valid,
    input  logic                   step_dir,
    input  logic [IDX_W-1:0]       step_s,
    input  logic [IDX_W-1:0]       step_t,
    input  logic                   step_last,
    output logic                   busy,
    output logic                   done,
    output logic signed [IO_W-1:0] x_out,
    output logic signed [IO_W-1:0] y_out
);
    import ols_pkg::*;

    localparam int DW     = IO_W + GUARD_W + HEAD_W;
    localparam int SW     = IDX_W + 1;
    localparam int THRESH = IO_W / 2 - 1;
    localparam logic signed [DW:0] HALF = (DW+1)'(1 << (GUARD_W - 1));
    localparam logic signed [DW:0] MAXV = (DW+1)'((1 << (IO_W - 1)) - 1);
    localparam logic signed [DW:0] MINV = -(DW+1)'(1 << (IO_W - 1));

    phase_e               phase;
    logic signed [DW-1:0] x_r, y_r, x_rot, y_rot, x_n, y_n;
    logic                 step_fire, finish;
    logic                 q_valid, q_empty, q_empty_next;
    logic [IDX_W-1:0]     q_idx;
    logic                 e_valid, e_zero_next, drain_en;
    logic [SW-1:0]        e_shift, sc_shift;
    scale_op_e            sc_op;

    // round half up, drop guard bits and saturate to the output range
    function automatic logic signed [IO_W-1:0] to_out(input logic signed [DW-1:0] v);
        logic signed [DW:0] w;
        w = {v[DW-1], v};
        w = (w + HALF) >>> GUARD_W;
        if (w > MAXV)      return MAXV[IO_W-1:0];
        else if (w < MINV) return MINV[IO_W-1:0];
        else               return w[IO_W-1:0];
    endfunction

    // handshake and phase decode
    always_comb begin
        step_ready = (phase == PH_ROT);
        busy       = (phase != PH_IDLE);
        step_fire  = step_ready && step_valid;
        drain_en   = (phase == PH_DRAIN) && q_empty;
    end

    ols_rotate_pair #(.DW(DW), .IW(IDX_W)) u_rot (
        .en(step_fire), .dir(step_dir), .sh_a(step_s), .sh_b(step_t),
        .x_i(x_r), .y_i(y_r), .x_o(x_rot), .y_o(y_rot)
    );

    ols_comp_queue #(.IW(IDX_W), .DEPTH(QDEPTH), .THRESH(THRESH)) u_queue (
        .clk(clk), .rst_n(rst_n), .active(busy), .in_valid(step_fire),
        .in_a(step_s), .in_b(step_t), .out_valid(q_valid), .out_idx(q_idx),
        .q_empty(q_empty), .empty_next(q_empty_next)
    );

    ols_err_bank #(.IW(IDX_W), .SW(SW), .CNT_W(CNT_W)) u_err (
        .clk(clk), .rst_n(rst_n), .inc_valid(step_fire), .idx_a(step_s),
        .idx_b(step_t), .drain_en(drain_en), .out_valid(e_valid),
        .out_shift(e_shift), .zero_next(e_zero_next)
    );

    // choose this cycle's gain step: shrink 2m+1, else trim, else none
    always_comb begin
        if (q_valid) begin
            sc_op    = SC_SHRINK;
            sc_shift = {q_idx, 1'b1};
        end else if (e_valid) begin
            sc_op    = SC_GROW;
            sc_shift = e_shift;
        end else begin
            sc_op    = SC_NONE;
            sc_shift = '0;
        end
    end

    for (genvar a = 0; a < 2; a++) begin : g_axis
        logic signed [DW-1:0] v_in, v_out;
        assign v_in = (a == 0) ? x_rot : y_rot;
        ols_scale_step #(.DW(DW), .SW(SW)) u_scale (
            .op(sc_op), .sh(sc_shift), .v_i(v_in), .v_o(v_out)
        );
        if (a == 0) begin : g_x
            assign x_n = v_out;
        end else begin : g_y
            assign y_n = v_out;
        end
    end

    // all owed work is complete after this edge
    always_comb begin
        finish = q_empty_next && e_zero_next &&
                 (((phase == PH_ROT) && step_fire && step_last) || (phase == PH_DRAIN));
    end

    // phase sequencing, datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            x_r   <= '0;
            y_r   <= '0;
            x_out <= '0;
            y_out <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (angle_zero) begin
                            x_out <= x_in;
                            y_out <= y_in;
                            done  <= 1'b1;
                        end else begin
                            x_r   <= {{HEAD_W{x_in[IO_W-1]}}, x_in, {GUARD_W{1'b0}}};
                            y_r   <= {{HEAD_W{y_in[IO_W-1]}}, y_in, {GUARD_W{1'b0}}};
                            phase <= PH_ROT;
                        end
                    end
                end
                PH_ROT, PH_DRAIN: begin
                    x_r <= x_n;
                    y_r <= y_n;
                    if (finish) begin
                        x_out <= to_out(x_n);
                        y_out <= to_out(y_n);
                        done  <= 1'b1;
                        phase <= PH_IDLE;
                    end else if (step_fire && step_last) begin
                        phase <= PH_DRAIN;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_TRIM_AFTER_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        e_valid |-> ((phase == PH_DRAIN) && !q_valid)); // R4

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(x_out) && $stable(y_out))); // R7

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && angle_zero && !busy) |=> (done && (x_out == $past(x_in)) && (y_out == $past(y_in)))); // R6

endmodule

// File: tb/online_scale_cordic_bench.sv
module online_scale_cordic_bench;

    typedef struct packed {
        logic signed [11:0] x;
        logic signed [11:0] y;
        logic [1:0]         n;
        logic [8:0]         s0;
        logic [8:0]         s1;
        logic [8:0]         s2;
    } vec_t;

    // beat encoding {dir, s[3:0], t[3:0]}
    localparam vec_t VECS [8] = '{
        '{12'sd500,  12'sd0,    2'd1, {1'b1,4'd1,4'd4}, 9'd0, 9'd0},
        '{12'sd450,  12'sd250,  2'd2, {1'b1,4'd1,4'd3}, {1'b0,4'd5,4'd7}, 9'd0},
        '{-12'sd500, 12'sd400,  2'd3, {1'b1,4'd2,4'd2}, {1'b1,4'd4,4'd8}, {1'b0,4'd6,4'd9}},
        '{12'sd0,    -12'sd500, 2'd2, {1'b1,4'd1,4'd2}, {1'b1,4'd6,4'd7}, 9'd0},
        '{12'sd650,  12'sd650,  2'd2, {1'b0,4'd3,4'd5}, {1'b0,4'd7,4'd10}, 9'd0},
        '{-12'sd700, -12'sd200, 2'd1, {1'b1,4'd6,4'd8}, 9'd0, 9'd0},
        '{12'sd300,  -12'sd700, 2'd3, {1'b1,4'd4,4'd4}, {1'b1,4'd5,4'd5}, {1'b1,4'd3,4'd9}},
        '{12'sd1000, 12'sd0,    2'd1, {1'b1,4'd8,4'd9}, 9'd0, 9'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, angle_zero = 1'b0;
    logic signed [11:0] x_in = '0, y_in = '0;
    logic step_ready, step_valid = 1'b0, step_dir = 1'b0, step_last = 1'b0;
    logic [3:0] step_s = '0, step_t = '0;
    logic busy, done;
    logic signed [11:0] x_out, y_out;

    int n_checks = 0;
    int n_fail = 0;
    logic [8:0] cur [3];
    int lat;

    always #2 clk = ~clk;

    online_scale_cordic u_online_scale_cordic (
        .clk(clk), .rst_n(rst_n), .start(start), .angle_zero(angle_zero),
        .x_in(x_in), .y_in(y_in), .step_ready(step_ready), .step_valid(step_valid),
        .step_dir(step_dir), .step_s(step_s), .step_t(step_t), .step_last(step_last),
        .busy(busy), .done(done), .x_out(x_out), .y_out(y_out)
    );

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_near(input string req, input string what, input int act, input real exp);
        real d;
        n_checks++;
        d = real'(act) - exp;
        if (d < 0.0) d = -d;
        if (d > 2.0) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %f", req, what, act, exp);
        end
    endtask

    function automatic real beat_angle(input logic [8:0] b);
        real a;
        a = $atan(1.0 / real'(1 << b[7:4])) + $atan(1.0 / real'(1 << b[3:0]));
        return b[8] ? a : -a;
    endfunction

    function automatic int owes_shrink(input int m);
        return (m >= 1 && m <= 5) ? 1 : 0;
    endfunction

    function automatic int owes_trim(input int m);
        return (m == 1 || m == 2) ? 2 : 0;
    endfunction

    // R5: Tr + leftover shrinks + trims, plus one for the sampling offset
    function automatic int exp_latency(input int n);
        int pend = 0;
        int trims = 0;
        for (int k = 0; k < n; k++) begin
            int e;
            e = owes_shrink(int'(cur[k][7:4])) + owes_shrink(int'(cur[k][3:0]));
            trims += owes_trim(int'(cur[k][7:4])) + owes_trim(int'(cur[k][3:0]));
            if (pend + e > 0) pend = pend + e - 1;
        end
        return n + pend + trims + 1;
    endfunction

    // drive one run; lat counts falling edges until done is seen
    task automatic run_case(input logic signed [11:0] xi, input logic signed [11:0] yi,
                            input logic az, input int n, input bit inject);
        int k = 0;
        @(negedge clk);
        x_in = xi; y_in = yi; angle_zero = az; start = 1'b1;
        @(negedge clk);
        start = 1'b0; angle_zero = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            if (step_ready && k < n) begin
                step_valid = 1'b1;
                step_dir   = cur[k][8];
                step_s     = cur[k][7:4];
                step_t     = cur[k][3:0];
                step_last  = (k == n - 1);
                k++;
            end else begin
                step_valid = 1'b0;
            end
            if (inject && lat == 2) begin
                start = 1'b1; x_in = 12'sd0; y_in = 12'sd0;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        step_valid = 1'b0; start = 1'b0;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R5 watchdog: actual no done expected done");
        end
    endtask

    task automatic run_vec(input int i, input bit inject, input string tag);
        real ang, xe, ye;
        int n;
        cur[0] = VECS[i].s0; cur[1] = VECS[i].s1; cur[2] = VECS[i].s2;
        n = int'(VECS[i].n);
        ang = 0.0;
        for (int k = 0; k < n; k++) ang += beat_angle(cur[k]);
        xe = real'(VECS[i].x) * $cos(ang) - real'(VECS[i].y) * $sin(ang);
        ye = real'(VECS[i].x) * $sin(ang) + real'(VECS[i].y) * $cos(ang);
        run_case(VECS[i].x, VECS[i].y, 1'b0, n, inject);
        chk_near({"R2 ", tag}, "x_out", int'(x_out), xe);
        chk_near({"R2 ", tag}, "y_out", int'(y_out), ye);
        chk_int({"R5 ", tag}, "latency", lat, exp_latency(n));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_int("R1", "done", int'(done), 0);
        chk_int("R1", "busy", int'(busy), 0);
        chk_int("R1", "step_ready", int'(step_ready), 0);
        chk_int("R1", "x_out", int'(x_out), 0);
        chk_int("R1", "y_out", int'(y_out), 0);

        // R2 R3 R4 R5: table of angles across 0..45 degrees and both turn senses
        for (int i = 0; i < 8; i++) run_vec(i, 1'b0, "vec");

        // R10: no beat taken once idle again
        chk_int("R10", "step_ready idle", int'(step_ready), 0);

        // R6 R8: zero angle passes extremes through exactly, done on next edge
        run_case(-12'sd2048, 12'sd2047, 1'b1, 0, 1'b0);
        chk_int("R6", "x_out", int'(x_out), -2048);
        chk_int("R6", "y_out", int'(y_out), 2047);
        chk_int("R6", "latency", lat, 1);

        // R7: outputs held and done low a cycle later
        @(negedge clk);
        chk_int("R7", "done low", int'(done), 0);
        chk_int("R7", "x_out held", int'(x_out), -2048);

        // R8: saturation of a result beyond full scale (ideal y about 2820)
        cur[0] = {1'b1, 4'd1, 4'd2};
        run_case(12'sd2000, 12'sd2000, 1'b0, 1, 1'b0);
        chk_int("R8", "y_out saturated", int'(y_out), 2047);

        // R9: start while busy ignored, same result and cycle count
        run_vec(6, 1'b1, "start-while-busy R9");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule